// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

This block collects message-signalled interrupts for up to 256 vectors and folds them into a single level interrupt line. An inbound memory write to the doorbell carries a vector number as its data. That write raises the pending bit of the vector it names. A write can arrive on the dedicated doorbell strobe or as a register write to the doorbell offset.

Software uses a simple 32-bit register port. It sees the pending bits as eight 32-bit words, which it acknowledges with write-1-to-clear. It masks or unmasks vectors through a second bank of eight read/write enable words, one bit per vector, using read-modify-write. The interrupt output is registered. It is high while at least one vector is both pending and enabled. The handler scans the pending words 32 vectors at a time to find the active ones.

Top module: `msi_agg_top`

## Requirements
- R1: While `rst` is high at a clock edge, every pending and enable bit is cleared. After that edge `irq` is 0 and every pending and enable word reads 0.
- R2: A doorbell carrying a value v in 0..255 sets pending bit v%32 of word v/32. That word is at byte offset 0x80 + 4*(v/32). A doorbell is either `db_valid` high with `db_data` = v, or a register write of v to offset 0x7C. The new bit is readable in the cycle after the edge. Both sources may ring in the same cycle.
- R3: A doorbell value of 256 or more changes no pending bit.
- R4: A register write to a pending word at 0x80..0x9C clears each pending bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R5: The enable words sit at 0xA0 + 4*w, with the same bit layout as the pending words. A write replaces the whole word, and a read returns it.
- R6: `irq` is a register. After each edge it shows whether any bit was both pending and enabled just before that edge. It therefore follows a state change one cycle later.
- R7: A doorbell sets its pending bit even while that vector is masked. Enabling the vector later raises `irq` one cycle after the enabling write.
- R8: A doorbell set and a write-1-to-clear may hit the same bit in the same cycle. The bit then ends up set.
- R9: These offsets read as 0: unaligned offsets, the doorbell offset, and offsets outside the doorbell, pending and enable ranges. Writes to unaligned or out-of-range offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| db_valid | input | 1 | Doorbell write strobe |
| db_data | input | 32 | Doorbell data, the vector number |
| irq | output | 1 | Summary interrupt, registered |

## Verification
A pending or enable bit held in the wrong state shows up in two places. The next read of its word returns the wrong value. If the partner bit of that vector is set, `irq` is also wrong one cycle after the faulty edge. The bench reads back the words that each doorbell, clear and mask operation touched. Because the reference model is compared with `irq` and the addressed read data every cycle, a corrupted bit or a wrong set/clear priority is caught within a cycle of the next access that exposes it. Rings at the last vector and at values just above range check the word and bit mapping at its edges.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

    localparam int WORD_W   = 32;
    localparam int BELL_OFS = 'h7C;
    localparam int PEND_OFS = 'h80;
    localparam int MASK_OFS = 'hA0;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_BELL = 2'd1,
        RGN_PEND = 2'd2,
        RGN_MASK = 2'd3
    } region_e;

    typedef struct packed {
        logic ring;
        logic clr_pend;
        logic wr_mask;
    } wr_cmd_t;

    function automatic region_e region_of(input logic [7:0] a, input int nw);
        int ia;
        ia = int'(a);
        if (a[1:0] != 2'b00)                                return RGN_NONE;
        if (ia == BELL_OFS)                                 return RGN_BELL;
        if (ia >= PEND_OFS && ia < PEND_OFS + 4 * nw)       return RGN_PEND;
        if (ia >= MASK_OFS && ia < MASK_OFS + 4 * nw)       return RGN_MASK;
        return RGN_NONE;
    endfunction

    function automatic int word_of(input logic [7:0] a, input region_e r);
        int ia;
        ia = int'(a);
        case (r)
            RGN_PEND: return (ia - PEND_OFS) / 4;
            RGN_MASK: return (ia - MASK_OFS) / 4;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/msi_agg_decode.sv
module msi_agg_decode
    import msi_agg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int IDX_W     = 3
) (
    input  logic [7:0]       addr,
    input  logic             we,
    output region_e          rgn,
    output logic [IDX_W-1:0] idx,
    output wr_cmd_t          cmd
);
    always_comb begin
        rgn          = region_of(addr, NUM_WORDS);
        idx          = IDX_W'(word_of(addr, rgn));
        cmd.ring     = we && (rgn == RGN_BELL);
        cmd.clr_pend = we && (rgn == RGN_PEND);
        cmd.wr_mask  = we && (rgn == RGN_MASK);
    end

    // R9: at most one write action per access
    always_comb begin
        assert_one_action_R9: assert ($onehot0({cmd.ring, cmd.clr_pend, cmd.wr_mask}));
    end
endmodule

// File: rtl/msi_agg_doorbell.sv
module msi_agg_doorbell
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic              db_valid,
    input  logic [31:0]       db_data,
    input  logic              reg_ring,
    input  logic [31:0]       reg_data,
    output logic [NUM_VEC-1:0] set_vec
);
    genvar v;
    generate
        for (v = 0; v < NUM_VEC; v++) begin : g_vec
            // full 32-bit compare drops values at or above NUM_VEC
            assign set_vec[v] = (db_valid && (db_data == 32'(v)))
                             || (reg_ring && (reg_data == 32'(v)));
        end
    endgenerate

    always_comb begin
        assert_two_sources_R2: assert ($countones(set_vec) <= 2);
        if (!reg_ring && (!db_valid || db_data >= 32'(NUM_VEC)))
            assert_range_ignored_R3: assert (set_vec == '0);
    end
endmodule

// File: rtl/msi_agg_bank.sv
module msi_agg_bank
    import msi_agg_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int IDX_W     = 3,
    localparam int NBITS    = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NBITS-1:0]  set_vec,
    input  logic              clr_en,
    input  logic              mask_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [NBITS-1:0]  status,
    output logic [NBITS-1:0]  enable
);
    logic [NBITS-1:0] clr_flat;

    genvar w;
    generate
        for (w = 0; w < NUM_WORDS; w++) begin : g_word
            logic              hit;
            logic [WORD_W-1:0] clr_word;
            logic [WORD_W-1:0] set_word;

            assign hit      = (wr_idx == IDX_W'(w));
            assign clr_word = (clr_en && hit) ? wdata : '0;
            assign set_word = set_vec[w*WORD_W +: WORD_W];
            assign clr_flat[w*WORD_W +: WORD_W] = clr_word;

            always_ff @(posedge clk) begin
                if (rst) begin
                    status[w*WORD_W +: WORD_W] <= '0;
                    enable[w*WORD_W +: WORD_W] <= '0;
                end else begin
                    // set after clear: a ring is never lost to an ack
                    status[w*WORD_W +: WORD_W] <=
                        (status[w*WORD_W +: WORD_W] & ~clr_word) | set_word;
                    if (mask_en && hit)
                        enable[w*WORD_W +: WORD_W] <= wdata;
                end
            end
        end
    endgenerate

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (status == '0 && enable == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(clr_flat & ~set_vec)) == '0));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !mask_en |=> $stable(enable));
endmodule

// File: rtl/msi_agg_irq.sv
module msi_agg_irq #(
    parameter int NBITS = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] status,
    input  logic [NBITS-1:0] enable,
    output logic             irq
);
    logic any_active;
    assign any_active = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_active;
    end

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (rst)
        any_active |=> irq);

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (rst)
        !any_active |=> !irq);
endmodule

// File: rtl/msi_agg_top.sv
module msi_agg_top
    import msi_agg_pkg::*;
#(
    parameter int NUM_VEC = 256,
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        db_valid,
    input  logic [31:0] db_data,
    output logic        irq
);
    region_e          rgn;
    logic [IDX_W-1:0] idx;
    wr_cmd_t          cmd;
    logic [NUM_VEC-1:0] set_vec;
    logic [NUM_VEC-1:0] status;
    logic [NUM_VEC-1:0] enable;

    msi_agg_decode #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
        .addr (reg_addr),
        .we   (reg_we),
        .rgn  (rgn),
        .idx  (idx),
        .cmd  (cmd)
    );

    msi_agg_doorbell #(.NUM_VEC(NUM_VEC)) u_bell (
        .db_valid (db_valid),
        .db_data  (db_data),
        .reg_ring (cmd.ring),
        .reg_data (reg_wdata),
        .set_vec  (set_vec)
    );

    msi_agg_bank #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_en  (cmd.clr_pend),
        .mask_en (cmd.wr_mask),
        .wr_idx  (idx),
        .wdata   (reg_wdata),
        .status  (status),
        .enable  (enable)
    );

    msi_agg_irq #(.NBITS(NUM_VEC)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .enable (enable),
        .irq    (irq)
    );

    always_comb begin
        case (rgn)
            RGN_PEND: reg_rdata = status[int'(idx)*WORD_W +: WORD_W];
            RGN_MASK: reg_rdata = enable[int'(idx)*WORD_W +: WORD_W];
            default:  reg_rdata = '0;
        endcase
    end

    assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && (!db_valid || db_data >= 32'(NUM_VEC))) |=> $stable(status));
endmodule

// File: tb/tb_msi_agg_top.sv
module tb_msi_agg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        db_valid = 1'b0;
    logic [31:0] db_data = 32'h0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    msi_agg_top dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
        .db_data(db_data), .irq(irq)
    );

    // behavioural reference model
    bit mst[256];
    bit men[256];
    bit m_irq;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r;
        int ia;
        r = 32'h0;
        ia = int'(a);
        if (a[1:0] == 2'b00) begin
            if (ia >= 'h80 && ia < 'hA0)
                for (int b = 0; b < 32; b++) r[b] = mst[(ia - 'h80) / 4 * 32 + b];
            else if (ia >= 'hA0 && ia < 'hC0)
                for (int b = 0; b < 32; b++) r[b] = men[(ia - 'hA0) / 4 * 32 + b];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin mst[i] = 0; men[i] = 0; end
            m_irq = 0;
        end else begin
            bit any;
            int ia;
            any = 0;
            for (int i = 0; i < 256; i++) if (mst[i] && men[i]) any = 1;
            ia = int'(reg_addr);
            if (reg_we && reg_addr[1:0] == 2'b00) begin
                if (ia >= 'h80 && ia < 'hA0)
                    for (int b = 0; b < 32; b++)
                        if (reg_wdata[b]) mst[(ia - 'h80) / 4 * 32 + b] = 0;
                if (ia >= 'hA0 && ia < 'hC0)
                    for (int b = 0; b < 32; b++)
                        men[(ia - 'hA0) / 4 * 32 + b] = reg_wdata[b];
                if (ia == 'h7C && reg_wdata < 256) mst[reg_wdata] = 1;
            end
            if (db_valid && db_data < 256) mst[db_data] = 1;
            m_irq = any;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2 R4 R5 R6 R9)
    always @(posedge clk) begin
        #5;
        if (!rst && !finished) begin
            check(irq == m_irq, "R6 cycle irq", 32'(irq), 32'(m_irq));
            check(reg_rdata == model_read(reg_addr), "R2/R4/R5/R9 cycle rdata",
                  reg_rdata, model_read(reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ring(input logic [31:0] v);
        @(negedge clk);
        db_valid = 1'b1; db_data = v;
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(posedge clk);
        #5;
        d = reg_rdata;
    endtask

    task automatic expect_word(input logic [7:0] a, input logic [31:0] exp,
                               input string req);
        logic [31:0] d;
        peek(a, d);
        check(d === exp, req, d, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check(irq === 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        expect_word(8'h80, 32'h0, "R1 pending word0");
        expect_word(8'hBC, 32'h0, "R1 enable word7");

        // R2 doorbell strobe, vector 5 -> word0 bit5; R7 masked, irq stays low
        ring(32'd5);
        expect_word(8'h80, 32'h0000_0020, "R2 strobe vector 5");
        check(irq === 1'b0, "R7 masked pending keeps irq low", 32'(irq), 32'h0);

        // R2 register doorbell, vector 70 -> word2 bit6
        wr(8'h7C, 32'd70);
        expect_word(8'h88, 32'h0000_0040, "R2 register ring vector 70");

        // R2 last vector 255 -> word7 bit31
        ring(32'd255);
        expect_word(8'h9C, 32'h8000_0000, "R2 vector 255");

        // R2 both sources in one cycle
        @(negedge clk);
        db_valid = 1'b1; db_data = 32'd33;
        reg_addr = 8'h7C; reg_we = 1'b1; reg_wdata = 32'd34;
        @(negedge clk);
        db_valid = 1'b0; reg_we = 1'b0;
        expect_word(8'h84, 32'h0000_0006, "R2 two sources same cycle");

        // R3 out-of-range values
        ring(32'd256);
        ring(32'hFFFF_FFFF);
        wr(8'h7C, 32'd300);
        expect_word(8'h80, 32'h0000_0020, "R3 word0 unchanged");
        expect_word(8'h84, 32'h0000_0006, "R3 word1 unchanged");
        expect_word(8'h9C, 32'h8000_0000, "R3 word7 unchanged");

        // R5 enable read/write
        wr(8'hA4, 32'hDEAD_BEE8);
        expect_word(8'hA4, 32'hDEAD_BEE8, "R5 enable word1 readback");

        // R6/R7 unmask vector 5 -> irq one cycle after the write edge
        wr(8'hA4, 32'h0);
        @(negedge clk);
        reg_addr = 8'hA0; reg_we = 1'b1; reg_wdata = 32'h0000_0020;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check(irq === 1'b0, "R6 irq not yet raised", 32'(irq), 32'h0);
        @(posedge clk); #5;
        check(irq === 1'b1, "R7 irq after unmask", 32'(irq), 32'h1);

        // R4 write of zero has no effect
        wr(8'h80, 32'h0);
        expect_word(8'h80, 32'h0000_0020, "R4 zero write keeps bit");

        // R4 clear vector 5, irq falls one cycle later (R6)
        wr(8'h80, 32'h0000_0020);
        #1;
        check(irq === 1'b1, "R6 irq still high right after clear", 32'(irq), 32'h1);
        expect_word(8'h80, 32'h0000_0000, "R4 bit cleared");
        check(irq === 1'b0, "R6 irq low after clear", 32'(irq), 32'h0);

        // R8 ring and clear same bit same cycle: set wins
        @(negedge clk);
        db_valid = 1'b1; db_data = 32'd5;
        reg_addr = 8'h80; reg_we = 1'b1; reg_wdata = 32'h0000_0020;
        @(negedge clk);
        db_valid = 1'b0; reg_we = 1'b0;
        expect_word(8'h80, 32'h0000_0020, "R8 set wins over clear");

        // R9 unmapped and unaligned accesses
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'hA2, 32'hFFFF_FFFF);
        wr(8'h82, 32'hFFFF_FFFF);
        expect_word(8'h40, 32'h0, "R9 unmapped read");
        expect_word(8'h7C, 32'h0, "R9 doorbell offset reads zero");
        expect_word(8'hA2, 32'h0, "R9 unaligned read");
        expect_word(8'hC0, 32'h0, "R9 beyond enable range");
        expect_word(8'hA0, 32'h0000_0020, "R9 enable untouched");
        expect_word(8'h80, 32'h0000_0020, "R9 pending untouched");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule